// File: doc/BRIEF.md
# Write-Completion Poll Engine

This block sits on the host side of a byte-programmable nonvolatile memory. It writes a burst of bytes, pulled one at a time from a data source, to consecutive addresses on a single-cycle memory port. It then finds out when the memory's internal programming has finished by reading status back, so it never has to wait a fixed worst-case delay. Completion is reported as a one-cycle `done` pulse. If the memory stays busy for too long, a one-cycle `timeout` pulse is raised instead. In both cases the engine returns to idle.

There are two ways to detect completion, and the host picks one at start. In the data-bit method, the engine re-reads the last address it wrote and compares bit 7 with the byte it stored there. In the toggle-bit method, it compares bit 6 across two back-to-back reads. Bursts longer than a page, or bursts that run across a page boundary, are split into page operations, and each page is polled on its own. A page is also closed early when the source is too slow to deliver the next byte within the byte-load window.

The controller has seven states:
- `ST_IDLE`: waiting for a start.
- `ST_FETCH`: waiting for a byte from the source.
- `ST_WRITE`: issuing a write.
- `ST_POLL_RD`: issuing a status read.
- `ST_POLL_WT`: evaluating the read response.
- `ST_DONE`: reporting completion.
- `ST_FAIL`: reporting a timeout.

The transitions are:
- `ST_IDLE` goes to `ST_FETCH` on start with a non-zero count.
- `ST_FETCH` goes to `ST_WRITE` when a byte is accepted, or to `ST_POLL_RD` when the byte-gap window of an open page expires.
- `ST_WRITE` goes to `ST_POLL_RD` after the last byte of the burst or of the page, and otherwise back to `ST_FETCH`.
- `ST_POLL_RD` always goes to `ST_POLL_WT`.
- `ST_POLL_WT` goes to `ST_DONE` when the page is complete and no bytes remain, to `ST_FETCH` when the page is complete and bytes remain, to `ST_FAIL` when the poll limit has passed, and otherwise back to `ST_POLL_RD`.
- `ST_DONE` and `ST_FAIL` both return to `ST_IDLE`.

Top module: `wrpoll_engine`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `mem_req` and `src_rdy` are all low.
- R2: A `start` in idle with a non-zero `byte_count` makes `busy` high in the next cycle. A `start` with `byte_count` zero, or any `start` while busy, is ignored: no port access takes place and no burst is changed.
- R3: A byte accepted from the source (`src_rdy` and `src_valid` both high) is written in the next cycle. Writes go to `start_addr`, `start_addr`+1, and so on, in the order the source delivered the bytes.
- R4: A page is 2^PAGE_BITS bytes, aligned. After the write whose address has all page-offset bits set, the next cycle is a poll read. Within a page, writes are never separated by poll reads unless R8 applies.
- R5: With `poll_mode` = 0 (data-bit method), every poll read goes to the last written address. The page is complete on the first response whose bit 7 equals bit 7 of the last written byte.
- R6: With `poll_mode` = 1 (toggle-bit method), the page is complete on the first response whose bit 6 equals bit 6 of the previous response of the same page. At least two poll reads are always needed.
- R7: When the final page completes, `done` is high for exactly the one cycle after the completing response. `busy` is low from the next cycle.
- R8: If no byte is accepted within GAP_LIMIT cycles after a write in an open page, the page is closed. Its first poll read is issued exactly GAP_LIMIT+2 cycles after that write. The remaining bytes then follow as a new page at the next addresses.
- R9: If a page does not complete, `timeout` pulses between POLL_LIMIT and POLL_LIMIT+4 cycles after the page's last write. `done` stays low, and the engine is idle in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start a burst (sampled in idle) |
| start_addr | input | AW | First byte address of the burst |
| byte_count | input | CW | Number of bytes in the burst; zero is ignored |
| poll_mode | input | 1 | 0: data-bit method, 1: toggle-bit method |
| src_valid | input | 1 | Source offers a byte |
| src_data | input | DW | Offered byte |
| src_rdy | output | 1 | Engine takes the offered byte this cycle |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Request is a write (else a read) |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle poll timeout pulse |

## Verification
Each check is placed at a fixed cycle offset from the stimulus that caused it:
- `busy` is checked one cycle after `start`.
- An accepted byte must appear as a write in the next cycle.
- The first poll read after a page-ending write must come in the next cycle, and after a byte-gap expiry exactly GAP_LIMIT+2 cycles after the last write.
- `done` must come exactly one cycle after the response that satisfies the selected completion rule, with that response located by the bench's own model of the memory.
- The timeout pulse only has to land inside a five-cycle window, because the read/evaluate alternation makes its exact cycle depend on parity.

All samples are taken on the falling clock edge, so every registered result has settled before it is compared.

// File: rtl/wrpoll_pkg.sv
package wrpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_POLL_RD,
        ST_POLL_WT,
        ST_DONE,
        ST_FAIL
    } eng_state_t;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } poll_mode_t;

endpackage

// File: rtl/wrpoll_timer.sv
// Saturating cycle counter: expired once LIMIT cycles have passed since clr.
module wrpoll_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 2);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= LIM);

    // R8 / R9 windows rely on the expiry holding until cleared
    p_expiry_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired)
        else $error("timer expiry dropped without clear");

endmodule

// File: rtl/wrpoll_addr_track.sv
// Current write address, bytes remaining and page-end detection.
module wrpoll_addr_track #(
    parameter int AW        = 19,
    parameter int CW        = 12,
    parameter int PAGE_BITS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_count,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] remain,
    output logic          last_byte,
    output logic          page_last
);
    localparam int OFF_HI = PAGE_BITS - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_count;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            remain   <= remain - 1'b1;
        end
    end

    assign last_byte = (remain == CW'(1));
    assign page_last = &cur_addr[OFF_HI:0];

endmodule

// File: rtl/wrpoll_poll_eval.sv
// Holds the last written address/data and judges each poll response.
module wrpoll_poll_eval
    import wrpoll_pkg::*;
#(
    parameter int            AW          = 19,
    parameter int            DW          = 8,
    parameter logic [DW-1:0] READY_MASK  = 8'h80,
    parameter logic [DW-1:0] TOGGLE_MASK = 8'h40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    input  poll_mode_t    mode,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic [AW-1:0] last_addr,
    output logic          hit
);
    logic [DW-1:0] last_data;
    logic [DW-1:0] prev_rsp;
    logic          have_prev;
    logic          data_match;
    logic          toggle_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
            prev_rsp  <= '0;
            have_prev <= 1'b0;
        end else if (capture) begin
            last_addr <= cap_addr;
            last_data <= cap_data;
            have_prev <= 1'b0;
        end else if (rsp_valid) begin
            prev_rsp  <= rsp_data;
            have_prev <= 1'b1;
        end
    end

    assign data_match   = ((rsp_data ^ last_data) & READY_MASK) == '0;
    assign toggle_match = have_prev && (((rsp_data ^ prev_rsp) & TOGGLE_MASK) == '0);

    always_comb begin
        hit = 1'b0;
        if (rsp_valid) begin
            unique case (mode)
                MODE_DATA:   hit = data_match;
                MODE_TOGGLE: hit = toggle_match;
                default:     hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wrpoll_engine.sv
module wrpoll_engine
    import wrpoll_pkg::*;
#(
    parameter int AW         = 19,
    parameter int CW         = 12,
    parameter int DW         = 8,
    parameter int PAGE_BITS  = 8,
    parameter int GAP_LIMIT  = 25000,
    parameter int POLL_LIMIT = 2600000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_count,
    input  logic          poll_mode,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_rdy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          timeout
);
    eng_state_t    state, nxt;
    poll_mode_t    mode_q;
    logic [DW-1:0] wdata_q;
    logic          page_open;

    logic [AW-1:0] cur_addr, last_addr;
    logic [CW-1:0] remain;
    logic          last_byte, page_last;
    logic          gap_exp, poll_exp, hit;
    logic          load, accept, in_poll, gap_close;

    assign load      = (state == ST_IDLE) && start && (byte_count != '0);
    assign accept    = src_rdy && src_valid;
    assign in_poll   = (state == ST_POLL_RD) || (state == ST_POLL_WT);
    assign gap_close = (state == ST_FETCH) && page_open && gap_exp;

    wrpoll_addr_track #(.AW(AW), .CW(CW), .PAGE_BITS(PAGE_BITS)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (start_addr),
        .load_count (byte_count),
        .step       (state == ST_WRITE),
        .cur_addr   (cur_addr),
        .remain     (remain),
        .last_byte  (last_byte),
        .page_last  (page_last)
    );

    wrpoll_poll_eval #(.AW(AW), .DW(DW)) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state == ST_WRITE),
        .cap_addr  (cur_addr),
        .cap_data  (wdata_q),
        .mode      (mode_q),
        .rsp_valid (state == ST_POLL_WT),
        .rsp_data  (mem_rdata),
        .last_addr (last_addr),
        .hit       (hit)
    );

    wrpoll_timer #(.LIMIT(GAP_LIMIT)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_FETCH),
        .expired (gap_exp)
    );

    wrpoll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_poll),
        .expired (poll_exp)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (load) nxt = ST_FETCH;
            ST_FETCH: begin
                if (gap_close)      nxt = ST_POLL_RD;
                else if (src_valid) nxt = ST_WRITE;
            end
            ST_WRITE:   nxt = (last_byte || page_last) ? ST_POLL_RD : ST_FETCH;
            ST_POLL_RD: nxt = ST_POLL_WT;
            ST_POLL_WT: begin
                if (hit)           nxt = (remain == '0) ? ST_DONE : ST_FETCH;
                else if (poll_exp) nxt = ST_FAIL;
                else               nxt = ST_POLL_RD;
            end
            ST_DONE:    nxt = ST_IDLE;
            ST_FAIL:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_DATA;
            wdata_q   <= '0;
            page_open <= 1'b0;
        end else begin
            if (load) begin
                mode_q    <= poll_mode_t'(poll_mode);
                page_open <= 1'b0;
            end
            if (accept)              wdata_q   <= src_data;
            if (state == ST_WRITE)   page_open <= 1'b1;
            else if (state == ST_POLL_WT && hit) page_open <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        src_rdy   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = last_addr;
        mem_wdata = wdata_q;
        busy      = 1'b1;
        done      = 1'b0;
        timeout   = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_FETCH:   src_rdy = !gap_close;
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_addr;
            end
            ST_POLL_RD: mem_req = 1'b1;
            ST_POLL_WT: ;
            ST_DONE:    done = 1'b1;
            ST_FAIL:    timeout = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    p_rise_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start))
        else $error("busy rose without start");

    p_write_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rdy && src_valid) |=> (mem_req && mem_we))
        else $error("accepted byte not written next cycle");

    p_poll_after_page_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (&mem_addr[PAGE_BITS-1:0])) |=> (mem_req && !mem_we))
        else $error("page end not followed by poll read");

    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done))
        else $error("engine not idle after done");

    p_idle_after_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (!busy && !mem_req))
        else $error("engine not idle after timeout");

endmodule

// File: tb/wrpoll_engine_tb.sv
`timescale 1ns/1ps
module wrpoll_engine_tb;
    localparam int AW = 12;
    localparam int CW = 10;
    localparam int DW = 8;
    localparam int PB = 4;
    localparam int GAP = 20;
    localparam int PL = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic          poll_mode = 1'b0;
    logic          src_valid;
    logic [DW-1:0] src_data;
    logic          src_rdy;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, timeout;

    wrpoll_engine #(.AW(AW), .CW(CW), .DW(DW), .PAGE_BITS(PB),
                    .GAP_LIMIT(GAP), .POLL_LIMIT(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .poll_mode(poll_mode), .src_valid(src_valid),
        .src_data(src_data), .src_rdy(src_rdy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .timeout(timeout)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 73 + 29);
    endfunction

    // memory model: busy for prog_cyc cycles after every write
    int         cyc = 0;
    int         busy_until = 0;
    int         prog_cyc = 15;
    logic [7:0] mem_arr [0:(1<<AW)-1];
    logic [7:0] lastw = '0;
    logic       tog = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we) begin
            mem_arr[mem_addr] <= mem_wdata;
            lastw <= mem_wdata;
            busy_until <= cyc + prog_cyc;
        end else if (mem_req) begin
            if (cyc < busy_until) begin
                mem_rdata <= {~lastw[7], tog, lastw[5:0]};
                tog <= ~tog;
            end else begin
                mem_rdata <= mem_arr[mem_addr];
            end
        end
    end

    // data source
    int   src_idx = 0;
    logic src_on = 1'b0;
    int   hold_idx = -1;
    int   hold_rel = 0;
    always @(posedge clk) if (src_rdy && src_valid) src_idx <= src_idx + 1;
    assign src_valid = src_on && ((src_idx != hold_idx) || (cyc >= hold_rel));
    assign src_data  = pat(src_idx);

    // monitor
    logic          tb_mode = 1'b0;
    int            wr_n = 0, rd_n = 0, bad_rd = 0, done_n = 0, to_n = 0;
    int            done_cyc = 0, to_cyc = 0, qual_cyc = -100;
    int            wr_addr [0:511];
    int            wr_data [0:511];
    int            wr_cyc  [0:511];
    int            wr_rdb  [0:511];
    int            rd_cyc  [0:2047];
    logic          rsp_pend = 1'b0, t_have = 1'b0, t_prev = 1'b0;
    logic [7:0]    last_wr_tb = '0;
    logic [AW-1:0] last_wa = '0;

    always @(negedge clk) begin
        if (rsp_pend) begin
            if (tb_mode == 1'b0 ? (mem_rdata[7] == last_wr_tb[7])
                                : (t_have && mem_rdata[6] == t_prev))
                qual_cyc = cyc;
            t_have = 1'b1;
            t_prev = mem_rdata[6];
        end
        rsp_pend = mem_req && !mem_we;
        if (mem_req && mem_we) begin
            if (wr_n < 512) begin
                wr_addr[wr_n] = int'(mem_addr);
                wr_data[wr_n] = int'(mem_wdata);
                wr_cyc[wr_n]  = cyc;
                wr_rdb[wr_n]  = rd_n;
            end
            wr_n++;
            last_wr_tb = mem_wdata;
            last_wa = mem_addr;
            t_have = 1'b0;
        end
        if (mem_req && !mem_we) begin
            if (rd_n < 2048) rd_cyc[rd_n] = cyc;
            rd_n++;
            if (mem_addr != last_wa) bad_rd++;
        end
        if (done)    begin done_n++; done_cyc = cyc; end
        if (timeout) begin to_n++;   to_cyc = cyc;   end
    end

    int n_chk = 0, n_bad = 0;
    int b_wr, b_rd, b_done, b_to, b_src, b_bad;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_burst(input int addr, input int cnt, input bit mode, input int prog);
        @(negedge clk);
        prog_cyc = prog;
        tb_mode  = mode;
        b_wr = wr_n; b_rd = rd_n; b_done = done_n; b_to = to_n; b_src = src_idx; b_bad = bad_rd;
        start_addr = AW'(addr);
        byte_count = CW'(cnt);
        poll_mode  = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            if (done_n > b_done || to_n > b_to) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_writes(input int addr, input int cnt, input string req);
        chk(wr_n - b_wr == cnt, req, wr_n - b_wr, cnt);
        for (int k = 0; k < cnt; k++) begin
            chk(wr_addr[b_wr + k] == addr + k, req, wr_addr[b_wr + k], addr + k);
            chk(wr_data[b_wr + k] == int'(pat(b_src + k)), req, wr_data[b_wr + k], int'(pat(b_src + k)));
        end
    endtask

    task automatic check_done(input string req);
        chk(done_n - b_done == 1, {req, " done count"}, done_n - b_done, 1);
        chk(done_cyc == qual_cyc + 1, {req, " done cycle"}, done_cyc, qual_cyc + 1);
        chk(busy == 1'b0, {req, " idle after done"}, busy, 0);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && timeout == 0, "R1 status low", busy, 0);
        chk(mem_req == 0 && src_rdy == 0, "R1 port idle", mem_req, 0);
    endtask

    task automatic t_single_data();
        start_burst(12'h123, 1, 1'b0, 15);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_end(500);
        check_writes(12'h123, 1, "R3 single");
        chk(bad_rd == b_bad, "R5 poll address", bad_rd - b_bad, 0);
        chk(rd_n - b_rd >= 2, "R5 polled while busy", rd_n - b_rd, 2);
        check_done("R7 single");
    endtask

    task automatic t_page_data();
        start_burst(12'h200, 16, 1'b0, 15);
        wait_end(800);
        check_writes(12'h200, 16, "R3 page");
        chk(wr_rdb[b_wr + 15] == b_rd, "R4 no mid-page poll", wr_rdb[b_wr + 15] - b_rd, 0);
        chk(rd_cyc[wr_rdb[b_wr + 15]] == wr_cyc[b_wr + 15] + 1, "R4 poll after last byte",
            rd_cyc[wr_rdb[b_wr + 15]], wr_cyc[b_wr + 15] + 1);
        chk(bad_rd == b_bad, "R5 page poll address", bad_rd - b_bad, 0);
        check_done("R7 page");
    endtask

    task automatic t_toggle();
        start_burst(12'h345, 8, 1'b1, 15);
        wait_end(800);
        check_writes(12'h345, 8, "R3 toggle");
        chk(rd_n - b_rd >= 2, "R6 two reads", rd_n - b_rd, 2);
        check_done("R6 toggle");
    endtask

    task automatic t_split();
        start_burst(12'h4FC, 10, 1'b0, 15);
        wait_end(1000);
        check_writes(12'h4FC, 10, "R3 split");
        chk(rd_cyc[wr_rdb[b_wr + 3]] == wr_cyc[b_wr + 3] + 1, "R4 poll at page end",
            rd_cyc[wr_rdb[b_wr + 3]], wr_cyc[b_wr + 3] + 1);
        chk(wr_rdb[b_wr + 4] > wr_rdb[b_wr + 3], "R4 page polled before next",
            wr_rdb[b_wr + 4] - wr_rdb[b_wr + 3], 1);
        check_done("R7 split");
    endtask

    task automatic t_gap();
        hold_idx = src_idx + 2;
        hold_rel = cyc + 300;
        start_burst(12'h600, 4, 1'b0, 15);
        wait_end(2000);
        check_writes(12'h600, 4, "R8 gap writes");
        chk(rd_cyc[wr_rdb[b_wr + 1]] == wr_cyc[b_wr + 1] + GAP + 2, "R8 gap close cycle",
            rd_cyc[wr_rdb[b_wr + 1]], wr_cyc[b_wr + 1] + GAP + 2);
        chk(wr_rdb[b_wr + 2] > wr_rdb[b_wr + 1], "R8 polled before resume",
            wr_rdb[b_wr + 2] - wr_rdb[b_wr + 1], 1);
        check_done("R8 gap");
        hold_idx = -1;
    endtask

    task automatic t_ignore();
        int saw_busy;
        start_burst(12'h050, 0, 1'b0, 15);
        saw_busy = 0;
        for (int i = 0; i < 8; i++) begin
            if (busy) saw_busy = 1;
            @(negedge clk);
        end
        chk(saw_busy == 0, "R2 zero count busy", saw_busy, 0);
        chk(wr_n == b_wr && rd_n == b_rd, "R2 zero count port", wr_n - b_wr, 0);
        start_burst(12'h700, 3, 1'b0, 15);
        @(negedge clk);
        start_addr = 12'h780;
        byte_count = CW'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(800);
        check_writes(12'h700, 3, "R2 start while busy");
        chk(done_n - b_done == 1, "R2 single completion", done_n - b_done, 1);
    endtask

    task automatic t_timeout();
        int w;
        start_burst(12'h0A0, 2, 1'b0, 100000);
        wait_end(1000);
        w = wr_cyc[b_wr + 1];
        chk(to_n - b_to == 1, "R9 timeout pulse", to_n - b_to, 1);
        chk(done_n == b_done, "R9 no done", done_n - b_done, 0);
        chk(to_cyc >= w + PL && to_cyc <= w + PL + 4, "R9 timeout window", to_cyc - w, PL);
        chk(busy == 1'b0, "R9 idle after timeout", busy, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        src_on = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_data();
        t_page_data();
        t_toggle();
        t_split();
        t_gap();
        t_ignore();
        t_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

endmodule